// File: doc/BRIEF.md
# Gate-Drive Output Steering with Chopping Carrier

This block sits between a three-phase PWM timing core and the six gate-drive pins. Each phase delivers a high-side and a low-side PWM signal. The block can swap the two signals of a phase, so that the pair drives the opposite pins. It can mix a high-frequency square carrier into the pins of either side so that pulse transformers can be driven. It can also gate each of the six pins on its own. A forced-off input from the shutdown logic clears all six pins without waiting for a clock.

Software sets the block through a small synchronous register port that can be read back. The port has three registers: the per-pin enables, the per-phase swap bits, and the carrier setup. The carrier setup holds the 8-bit divider and one chopping enable for each side. The signals pass through in a fixed order: swap first, then chopping by pin side, then the pin enable, then forced-off. Every output is active-high, and the OFF level is 0. The PWM inputs and the gate outputs are plain level signals with no handshake, because the pins must follow the timing core at all times and cannot apply back-pressure.

Top module: `pwm_gate_steer`

## Requirements
- R1: After reset, all registers read 0 and every gate output is 0 whatever the PWM inputs are.
- R2: Enable bit 2p gates the high pin of phase p and bit 2p+1 gates its low pin. The enables sit at address 0, bits [5:0]. A cleared bit holds that pin at 0.
- R3: Swap bit p sits at address 1, bits [2:0]. When it is set, the high pin of phase p follows the low PWM input and the low pin follows the high PWM input. When it is clear, each pin follows its own input.
- R4: A write takes effect at the clock edge where cfg_wr is high. cfg_rdata shows the register that cfg_addr selects, without a clock. Unused bits read 0.
- R5: The carrier register sits at address 2: the divider in bits [7:0], high-side chopping in bit 8, low-side chopping in bit 9. Any write to this address restarts the carrier high. The carrier then stays high for divider+1 cycles and low for divider+1 cycles, repeating.
- R6: With high-side chopping on, every high pin is its steered signal ANDed with the carrier. The low pins are not affected.
- R7: With low-side chopping on, every low pin is its steered signal ANDed with the carrier. The high pins are not affected.
- R8: Chopping follows the pin side after the swap, not the side of the input signal.
- R9: While force_off is high, all six gate outputs are 0 at once, without waiting for a clock edge.
- R10: A write to address 3 changes no register and no output, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the PWM timing core |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for cfg_addr |
| pwm_hi | input | 3 | High-side PWM signal per phase |
| pwm_lo | input | 3 | Low-side PWM signal per phase |
| force_off | input | 1 | Shutdown override, drives all outputs to 0 |
| gate_hi | output | 3 | High-side gate pin per phase |
| gate_lo | output | 3 | Low-side gate pin per phase |

## Verification
The hardest case to reach is a swapped phase combined with chopping on only one side. There the pins show whether chopping follows the pin side or the source signal. The stimulus swaps phase 0 with only the high input active and chops only the high side. It then watches the low pin over a whole carrier period: that pin must stay steady while the high pins keep pulsing. The carrier phase is counted in cycles from the restarting write. This lets every sample be predicted for a divider of 2 and for a divider of 0.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

  typedef enum logic [1:0] {
    ADDR_EN    = 2'd0,
    ADDR_XO    = 2'd1,
    ADDR_CHOP  = 2'd2,
    ADDR_SPARE = 2'd3
  } cfg_addr_e;

  localparam int CHOP_HI_BIT_OFS = 0;
  localparam int CHOP_LO_BIT_OFS = 1;

endpackage

// File: rtl/pwm_steer_regs.sv
module pwm_steer_regs
  import pwm_steer_pkg::*;
#(
  parameter int PHASES = 3,
  parameter int DIV_W  = 8,
  parameter int CFG_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [1:0]          cfg_addr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_rdata,
  output logic [2*PHASES-1:0] out_en,
  output logic [PHASES-1:0]   xover,
  output logic [DIV_W-1:0]    chop_div,
  output logic                chop_hi,
  output logic                chop_lo,
  output logic                chop_wr
);

  localparam int EN_W = 2 * PHASES;

  logic wr_en, wr_xo;

  assign wr_en   = cfg_wr && (cfg_addr == ADDR_EN);
  assign wr_xo   = cfg_wr && (cfg_addr == ADDR_XO);
  assign chop_wr = cfg_wr && (cfg_addr == ADDR_CHOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_en   <= '0;
      xover    <= '0;
      chop_div <= '0;
      chop_hi  <= 1'b0;
      chop_lo  <= 1'b0;
    end else begin
      if (wr_en) out_en <= cfg_wdata[EN_W-1:0];
      if (wr_xo) xover  <= cfg_wdata[PHASES-1:0];
      if (chop_wr) begin
        chop_div <= cfg_wdata[DIV_W-1:0];
        chop_hi  <= cfg_wdata[DIV_W+CHOP_HI_BIT_OFS];
        chop_lo  <= cfg_wdata[DIV_W+CHOP_LO_BIT_OFS];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      ADDR_EN:   cfg_rdata[EN_W-1:0] = out_en;
      ADDR_XO:   cfg_rdata[PHASES-1:0] = xover;
      ADDR_CHOP: begin
        cfg_rdata[DIV_W-1:0]                = chop_div;
        cfg_rdata[DIV_W+CHOP_HI_BIT_OFS]    = chop_hi;
        cfg_rdata[DIV_W+CHOP_LO_BIT_OFS]    = chop_lo;
      end
      default:   cfg_rdata = '0;
    endcase
  end

  // R10: spare address writes leave every register alone
  assert_spare_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == ADDR_SPARE) |=>
      ($stable(out_en) && $stable(xover) && $stable(chop_div) &&
       $stable(chop_hi) && $stable(chop_lo)));

  // R4: a write to the enable register lands on the next cycle
  assert_en_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (out_en == $past(cfg_wdata[EN_W-1:0])));

endmodule

// File: rtl/pwm_chop_carrier.sv
module pwm_chop_carrier #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             carrier
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      carrier <= 1'b1;
    end else if (restart) begin
      cnt     <= '0;
      carrier <= 1'b1;
    end else if (cnt == div) begin
      cnt     <= '0;
      carrier <= ~carrier;
    end else begin
      cnt     <= cnt + 1'b1;
    end
  end

  // R5: a reconfiguring write restarts the carrier high with a cleared count
  assert_restart_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (carrier && cnt == '0));

  // R5: the half-period counter never passes the divider
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= div);

  // R5: the carrier holds until its half period is used up
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && cnt != div) |=> $stable(carrier));

endmodule

// File: rtl/pwm_phase_steer.sv
module pwm_phase_steer (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_hi,
  input  logic pwm_lo,
  input  logic xover,
  input  logic en_hi,
  input  logic en_lo,
  input  logic chop_hi,
  input  logic chop_lo,
  input  logic carrier,
  input  logic force_off,
  output logic gate_hi,
  output logic gate_lo
);

  logic sw_hi, sw_lo;
  logic ch_hi, ch_lo;

  // swap stage, then chopping by pin side, then enable, then override
  assign sw_hi = xover ? pwm_lo : pwm_hi;
  assign sw_lo = xover ? pwm_hi : pwm_lo;

  assign ch_hi = chop_hi ? (sw_hi & carrier) : sw_hi;
  assign ch_lo = chop_lo ? (sw_lo & carrier) : sw_lo;

  assign gate_hi = ch_hi & en_hi & ~force_off;
  assign gate_lo = ch_lo & en_lo & ~force_off;

  // R9: override wins over every setting
  assert_force_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |-> (!gate_hi && !gate_lo));

  // R2: a disabled pin never drives
  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_hi |-> !gate_hi) and (!en_lo |-> !gate_lo));

  // R3: a swapped, unchopped, enabled pair follows the opposite inputs
  assert_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xover && en_hi && en_lo && !chop_hi && !chop_lo && !force_off) |->
      (gate_hi == pwm_lo && gate_lo == pwm_hi));

  // R6: with the carrier low, a chopped high pin is off
  assert_chop_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chop_hi && !carrier) |-> !gate_hi);

  // R7: with the carrier low, a chopped low pin is off
  assert_chop_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chop_lo && !carrier) |-> !gate_lo);

endmodule

// File: rtl/pwm_gate_steer.sv
module pwm_gate_steer #(
  parameter int PHASES = 3,
  parameter int DIV_W  = 8,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [PHASES-1:0] pwm_hi,
  input  logic [PHASES-1:0] pwm_lo,
  input  logic              force_off,
  output logic [PHASES-1:0] gate_hi,
  output logic [PHASES-1:0] gate_lo
);

  localparam int EN_W = 2 * PHASES;

  logic [EN_W-1:0]   out_en;
  logic [PHASES-1:0] xover;
  logic [DIV_W-1:0]  chop_div;
  logic              chop_hi, chop_lo, chop_wr;
  logic              carrier;

  pwm_steer_regs #(.PHASES(PHASES), .DIV_W(DIV_W), .CFG_W(CFG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .out_en    (out_en),
    .xover     (xover),
    .chop_div  (chop_div),
    .chop_hi   (chop_hi),
    .chop_lo   (chop_lo),
    .chop_wr   (chop_wr)
  );

  pwm_chop_carrier #(.DIV_W(DIV_W)) u_carrier (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (chop_wr),
    .div     (chop_div),
    .carrier (carrier)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    pwm_phase_steer u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwm_hi    (pwm_hi[p]),
      .pwm_lo    (pwm_lo[p]),
      .xover     (xover[p]),
      .en_hi     (out_en[2*p]),
      .en_lo     (out_en[2*p+1]),
      .chop_hi   (chop_hi),
      .chop_lo   (chop_lo),
      .carrier   (carrier),
      .force_off (force_off),
      .gate_hi   (gate_hi[p]),
      .gate_lo   (gate_lo[p])
    );
  end

  // R1: reset leaves every pin quiet on the first cycle
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (gate_hi == '0 && gate_lo == '0));

endmodule

// File: tb/pwm_gate_steer_bench.sv
module pwm_gate_steer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [2:0]  pwm_hi = '0;
  logic [2:0]  pwm_lo = '0;
  logic        force_off = 1'b0;
  logic [2:0]  gate_hi, gate_lo;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pwm_gate_steer u_pwm_gate_steer (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pwm_hi(pwm_hi),
    .pwm_lo(pwm_lo), .force_off(force_off), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  // fields: en[20:15] xo[14:12] hi[11:9] lo[8:6] exp_hi[5:3] exp_lo[2:0]
  localparam logic [20:0] VEC [8] = '{
    {6'b111111, 3'b000, 3'b101, 3'b010, 3'b101, 3'b010},
    {6'b111111, 3'b111, 3'b101, 3'b010, 3'b010, 3'b101},
    {6'b010101, 3'b000, 3'b111, 3'b111, 3'b111, 3'b000},
    {6'b101010, 3'b000, 3'b111, 3'b111, 3'b000, 3'b111},
    {6'b111111, 3'b001, 3'b001, 3'b000, 3'b000, 3'b001},
    {6'b000011, 3'b010, 3'b111, 3'b000, 3'b001, 3'b000},
    {6'b001100, 3'b010, 3'b010, 3'b000, 3'b000, 3'b010},
    {6'b111111, 3'b100, 3'b000, 3'b100, 3'b100, 3'b000}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    pwm_hi = 3'b111; pwm_lo = 3'b111;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 gates in reset", {10'b0, gate_hi, gate_lo}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], r);
      check("R1 register reset value", r, 16'h0);
    end
    check("R1 gates after reset", {10'b0, gate_hi, gate_lo}, 16'h0);

    // R2 R3: steering table with chopping off
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, {10'b0, VEC[i][20:15]});
      wr(2'd1, {13'b0, VEC[i][14:12]});
      pwm_hi = VEC[i][11:9]; pwm_lo = VEC[i][8:6];
      #1;
      check("R2 R3 table high pins", {13'b0, gate_hi}, {13'b0, VEC[i][5:3]});
      check("R2 R3 table low pins", {13'b0, gate_lo}, {13'b0, VEC[i][2:0]});
    end

    // R4: readback of written values, unused bits zero
    wr(2'd0, 16'hFFD5);
    rd(2'd0, r); check("R4 enable readback", r, 16'h0015);
    wr(2'd1, 16'hFFF6);
    rd(2'd1, r); check("R4 swap readback", r, 16'h0006);

    // R5 R6: high-side chopping, divider 2 -> 3 high, 3 low
    wr(2'd0, 16'h003F);
    wr(2'd1, 16'h0000);
    pwm_hi = 3'b111; pwm_lo = 3'b000;
    wr(2'd2, 16'hFD02);
    rd(2'd2, r); check("R4 R5 carrier readback", r, 16'h0102);
    for (int k = 0; k < 12; k++) begin
      #1;
      check("R5 R6 chopped high pins", {13'b0, gate_hi},
            ((k / 3) % 2 == 0) ? 16'h0007 : 16'h0000);
      check("R6 low pins untouched", {13'b0, gate_lo}, 16'h0);
      @(negedge clk);
    end

    // R7: low-side chopping, divider 0 -> toggles each cycle
    pwm_hi = 3'b101; pwm_lo = 3'b111;
    wr(2'd2, 16'h0200);
    for (int k = 0; k < 6; k++) begin
      #1;
      check("R7 chopped low pins", {13'b0, gate_lo}, (k % 2 == 0) ? 16'h0007 : 16'h0000);
      check("R7 high pins untouched", {13'b0, gate_hi}, 16'h0005);
      @(negedge clk);
    end

    // R8: swap on phase 0, chop high only: steered low pin stays steady
    wr(2'd1, 16'h0001);
    pwm_hi = 3'b111; pwm_lo = 3'b000;
    wr(2'd2, 16'h0102);
    for (int k = 0; k < 6; k++) begin
      #1;
      check("R8 swapped low pin unchopped", {13'b0, gate_lo}, 16'h0001);
      check("R8 high pins chopped", {13'b0, gate_hi},
            ((k / 3) % 2 == 0) ? 16'h0006 : 16'h0000);
      @(negedge clk);
    end

    // R9: forced off without a clock edge
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0000);
    pwm_hi = 3'b111; pwm_lo = 3'b111;
    #1;
    check("R9 before override", {10'b0, gate_hi, gate_lo}, 16'h003F);
    #3 force_off = 1'b1;
    #1;
    check("R9 override immediate", {10'b0, gate_hi, gate_lo}, 16'h0);
    @(negedge clk);
    check("R9 override held", {10'b0, gate_hi, gate_lo}, 16'h0);
    force_off = 1'b0;
    #1;
    check("R9 release", {10'b0, gate_hi, gate_lo}, 16'h003F);

    // R10: spare address write changes nothing
    wr(2'd3, 16'h0000);
    check("R10 outputs unchanged", {10'b0, gate_hi, gate_lo}, 16'h003F);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, r); check("R10 spare reads zero", r, 16'h0);
    rd(2'd0, r); check("R10 enables unchanged", r, 16'h003F);
    rd(2'd1, r); check("R10 swap unchanged", r, 16'h0000);
    rd(2'd2, r); check("R10 carrier unchanged", r, 16'h0000);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule